// File: doc/BRIEF.md
# Flash Security State Register

This block keeps the 8-bit security state of a nonvolatile memory controller. Once reset is released it makes one read of the security byte at a fixed configuration address. It captures the returned byte and its error flags on a valid strobe, and then raises a done flag that other logic can use to let the core start. Until that load completes, the register reads all ones, so the device counts as secured.

The register has three fields. The top two bits form the key-access field, the middle four bits are reserved, and the bottom two bits form the lock field. Two status outputs are decoded from the current contents: a lock status and a key-access status. For each field, only the code 10 grants access.

The register cannot be written from the bus. A double-bit fault on the fetch forces the register to all ones. A single-bit fault only means the data was corrected, and that data is loaded. A pulse that reports a successful key-based unlock forces the lock field to 10 and leaves the other bits as they are. Such a pulse is honoured only after the load has finished.

Top module: `fsec_state_reg`

## Requirements
- R1: While reset is asserted, and after reset until the load completes, `sec_q_o` reads 8'hFF, `load_done_o` is 0, `secured_o` is 1 and `key_en_o` is 0.
- R2: After reset release, `rd_req_o` goes high for exactly one cycle with `rd_addr_o` equal to the configured address (default 18'h3FF0F). No further request is made until the next reset.
- R3: While the block waits for data, the clock edge that samples `rd_valid_i` high loads `rd_data_i` into `sec_q_o` and sets `load_done_o` to 1. Both are visible after that edge.
- R4: If `rd_dbe_i` is high with the valid strobe, `sec_q_o` becomes 8'hFF whatever the data.
- R5: A high `rd_sbe_i` with the valid strobe, and no double-bit flag, has no effect: `rd_data_i` is loaded as is.
- R6: `secured_o` is 0 only when `sec_q_o[1:0]` is 2'b10. The codes 00, 01 and 11 give 1.
- R7: `key_en_o` is 1 only when `sec_q_o[7:6]` is 2'b10. The codes 00, 01 and 11 give 0.
- R8: A bus write (`bus_wr_i` high with any `bus_wdata_i`) never changes `sec_q_o`.
- R9: When `load_done_o` is 1, an `unlock_i` pulse sets `sec_q_o[1:0]` to 2'b10 on the next edge. `sec_q_o[7:2]` is left unchanged.
- R10: An `unlock_i` pulse while `load_done_o` is 0 has no effect: `sec_q_o` stays 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_req_o | output | 1 | One-cycle read request for the security byte |
| rd_addr_o | output | 18 | Address of the configuration byte |
| rd_valid_i | input | 1 | Read data valid strobe |
| rd_data_i | input | 8 | Read data (ECC-corrected) |
| rd_sbe_i | input | 1 | Single-bit error was corrected |
| rd_dbe_i | input | 1 | Uncorrectable double-bit error |
| bus_wr_i | input | 1 | Bus write strobe to the register (ignored) |
| bus_wdata_i | input | 8 | Bus write data (ignored) |
| unlock_i | input | 1 | Successful key-based unlock pulse |
| sec_q_o | output | 8 | Register contents |
| load_done_o | output | 1 | Reset-time load complete |
| secured_o | output | 1 | Device is secured |
| key_en_o | output | 1 | Key-based access is enabled |

## Verification
The read request shows up one edge after reset is released. The loaded byte and the done flag appear on the edge that samples the valid strobe. An unlock takes effect on the edge that samples the pulse. The two status outputs follow the register in the same cycle with no extra delay. The bench drives inputs and samples outputs on falling edges, one negedge after the rising edge on which each result is due. It therefore reads the loaded value right after the strobe cycle, the forced lock field right after the unlock cycle, and the held value right after a write or an early unlock pulse.

// File: rtl/fsec_pkg.sv
package fsec_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_WAIT = 2'd2,
    LD_DONE = 2'd3
  } ld_state_e;

  localparam int unsigned SEC_W     = 8;
  localparam logic [1:0]  CODE_OPEN = 2'b10;
  localparam logic [SEC_W-1:0] SEC_LOCKED = '1;
endpackage

// File: rtl/fsec_loader.sv
module fsec_loader
  import fsec_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 18,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 18'h3FF0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              load_en_o,
  output logic              done_o
);
  ld_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_IDLE: state_d = LD_REQ;
      LD_REQ:  state_d = LD_WAIT;
      LD_WAIT: if (rd_valid_i) state_d = LD_DONE;
      default: state_d = LD_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LD_IDLE;
    else         state_q <= state_d;
  end

  assign rd_req_o  = (state_q == LD_REQ);
  assign rd_addr_o = CFG_ADDR;
  assign load_en_o = (state_q == LD_WAIT) && rd_valid_i;
  assign done_o    = (state_q == LD_DONE);

  p_req_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  p_done_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_load_sets_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_o |=> done_o);
endmodule

// File: rtl/fsec_store.sv
module fsec_store
  import fsec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [SEC_W-1:0] load_data_i,
  input  logic             sbe_i,
  input  logic             dbe_i,
  input  logic             done_i,
  input  logic             unlock_i,
  output logic [SEC_W-1:0] q_o
);
  logic [SEC_W-1:0] q_q;

  // sbe_i needs no action: data arrives corrected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= SEC_LOCKED;
    end else if (load_en_i) begin
      q_q <= dbe_i ? SEC_LOCKED : load_data_i;
    end else if (done_i && unlock_i) begin
      q_q[1:0] <= CODE_OPEN;
    end
  end

  assign q_o = q_q;

  p_locked_until_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> q_o == SEC_LOCKED);
  p_dbe_forces_ones_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en_i && dbe_i) |=> q_o == SEC_LOCKED);
  p_sbe_loads_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en_i && sbe_i && !dbe_i) |=> q_o == $past(load_data_i));
  p_unlock_opens_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && unlock_i) |=> (q_o[1:0] == CODE_OPEN) && (q_o[7:2] == $past(q_o[7:2])));
endmodule

// File: rtl/fsec_decode.sv
module fsec_decode
  import fsec_pkg::*;
(
  input  logic [1:0] key_fld_i,
  input  logic [1:0] lock_fld_i,
  output logic       secured_o,
  output logic       key_en_o
);
  assign secured_o = (lock_fld_i != CODE_OPEN);
  assign key_en_o  = (key_fld_i == CODE_OPEN);
endmodule

// File: rtl/fsec_state_reg.sv
module fsec_state_reg
  import fsec_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 18,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 18'h3FF0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_sbe_i,
  input  logic              rd_dbe_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic              unlock_i,
  output logic [7:0]        sec_q_o,
  output logic              load_done_o,
  output logic              secured_o,
  output logic              key_en_o
);
  logic load_en, done;

  fsec_loader #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_loader (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_valid_i(rd_valid_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .load_en_o (load_en),
    .done_o    (done)
  );

  fsec_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_en_i  (load_en),
    .load_data_i(rd_data_i),
    .sbe_i      (rd_sbe_i),
    .dbe_i      (rd_dbe_i),
    .done_i     (done),
    .unlock_i   (unlock_i),
    .q_o        (sec_q_o)
  );

  fsec_decode u_decode (
    .key_fld_i (sec_q_o[7:6]),
    .lock_fld_i(sec_q_o[1:0]),
    .secured_o (secured_o),
    .key_en_o  (key_en_o)
  );

  assign load_done_o = done;

  // bus writes have no path into the register
  p_write_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_done_o && bus_wr_i && (bus_wdata_i != sec_q_o) && !unlock_i) |=> $stable(sec_q_o));
  p_early_unlock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_done_o && !rd_valid_i && unlock_i) |=> sec_q_o == SEC_LOCKED);
endmodule

// File: tb/fsec_state_reg_tb_top.sv
module fsec_state_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req;
  logic [17:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = '0;
  logic        rd_sbe = 1'b0, rd_dbe = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        unlock = 1'b0;
  logic [7:0]  sec_q;
  logic        done, secured, key_en;

  int checks = 0, fails = 0, req_cnt = 0;

  always #5 clk = ~clk;

  fsec_state_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .rd_sbe_i(rd_sbe), .rd_dbe_i(rd_dbe),
    .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata),
    .unlock_i(unlock),
    .sec_q_o(sec_q), .load_done_o(done),
    .secured_o(secured), .key_en_o(key_en)
  );

  always @(posedge clk) if (rst_n && rd_req) req_cnt <= req_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input logic [7:0] e, input bit e_done, input string req);
    logic e_sec, e_key;
    e_sec = (e[1:0] != 2'b10);        // R6
    e_key = (e[7:6] == 2'b10);        // R7
    chk(sec_q == e, req, sec_q, e);
    chk(done == e_done, {req, " done"}, done, e_done);
    chk(secured == e_sec, "R6", secured, e_sec);
    chk(key_en == e_key, "R7", key_en, e_key);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int v = 0; v < 256; v++) begin
      for (int e = 0; e < 3; e++) begin
        logic [7:0] exp_q;
        int wait_n;
        rst_n = 1'b0;
        @(negedge clk);
        chk_state(8'hFF, 1'b0, "R1 reset");
        @(negedge clk);
        req_cnt = 0;
        rst_n = 1'b1;
        chk_state(8'hFF, 1'b0, "R1 post-reset");
        // R2: request due one edge after release
        @(negedge clk);
        chk(rd_req == 1'b1, "R2 req", rd_req, 1);
        chk(rd_addr == 18'h3FF0F, "R2 addr", rd_addr, 18'h3FF0F);
        // R10: early unlock during wait
        unlock = ((v + e) % 2 == 0);
        @(negedge clk);
        unlock = 1'b0;
        chk(rd_req == 1'b0, "R2 single", rd_req, 0);
        chk_state(8'hFF, 1'b0, "R10 early unlock");
        wait_n = v % 3;
        for (int k = 0; k < wait_n; k++) @(negedge clk);
        rd_valid = 1'b1;
        rd_data  = v[7:0];
        rd_sbe   = (e == 1);
        rd_dbe   = (e == 2);
        @(negedge clk);
        rd_valid = 1'b0; rd_sbe = 1'b0; rd_dbe = 1'b0;
        rd_data  = ~rd_data;
        exp_q = (e == 2) ? 8'hFF : v[7:0];
        chk_state(exp_q, 1'b1, e == 2 ? "R4 dbe" : (e == 1 ? "R5 sbe" : "R3 load"));
        // R8: write (no unlock) leaves contents unchanged
        bus_wr = 1'b1;
        bus_wdata = ~exp_q;
        @(negedge clk);
        bus_wr = 1'b0;
        chk_state(exp_q, 1'b1, "R8 write");
        // R9: unlock after done
        unlock = 1'b1;
        @(negedge clk);
        unlock = 1'b0;
        exp_q = {exp_q[7:2], 2'b10};
        chk_state(exp_q, 1'b1, "R9 unlock");
        @(negedge clk);
        chk(req_cnt == 1, "R2 count", req_cnt, 1);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule